// File: doc/BRIEF.md
# Multi-phase PWM channel rotator

This block sits between four PWM compare channels (A, B, C, D) and their output pins. It arranges the channels into rotation groups, and in any one timer period only one channel of a group may pass its waveform to the pin. The other channels of that group are held low. At each period boundary the permitted channel moves on to the next member of the group.

A 3-bit phase-mode field selects the grouping. It can form one group of two, three or four channels, or two independent pairs. The field can only be changed while the timer is stopped. When the timer starts, every group begins again from its first channel.

The block exposes the current rotation index of each group, so that other logic can follow the phase sequence. It does not generate the compare waveforms and does no bus decoding beyond a single write strobe.

Top module: `phase_rotator`

## Requirements
- R1: After reset the phase mode is 000, both phase indices are 0 and every channel passes through (pwm_out equals pwm_in).
- R2: With phase mode 000, or any reserved code (101, 110, 111), pwm_out equals pwm_in every cycle, and the indices stay 0.
- R3: Mode 001 groups A (bit 0) and B (bit 1): bit 0 passes only when phase_a is 0, bit 1 only when phase_a is 1, and C (bit 2) and D (bit 3) pass unchanged.
- R4: Mode 010 groups A, B and C: channel bit k (k = 0..2) passes only when phase_a equals k, and D (bit 3) passes unchanged.
- R5: Mode 011 groups all four channels: channel bit k passes only when phase_a equals k.
- R6: Mode 100 forms two pairs. A and B pass according to phase_a (0 selects A, 1 selects B), and C and D pass according to phase_b (0 selects C, 1 selects D).
- R7: On a clock edge with run and period_end both high, phase_a advances by one and wraps from the last member of its group (1, 2, 3 or 1 for modes 001, 010, 011, 100) to 0. phase_b toggles in mode 100. Without such an edge the indices hold.
- R8: period_end has no effect while run is low.
- R9: A mode write (wr_en high) is taken only while run is low. A taken write also clears both indices. A write while run is high is ignored.
- R10: On the first clock edge where run is high after being low, both indices are cleared, so the first period of a run uses the first channel of each group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Timer-run flag |
| period_end | input | 1 | One-cycle strobe at each timer period boundary |
| wr_en | input | 1 | Phase-mode write strobe |
| wr_mode | input | 3 | Phase-mode value to write |
| pwm_in | input | 4 | Raw channel waveforms, bit 0 = A to bit 3 = D |
| pwm_out | output | 4 | Gated channel waveforms, same bit order |
| phase_a | output | 2 | Rotation index of the group containing A |
| phase_b | output | 1 | Rotation index of the C/D pair (mode 100) |

## Verification
The assertions assume that run, period_end and wr_en are clean synchronous levels. They also assume that the internal mode can only change through a write taken while run is low, so a rotation index never goes past its group's last member. The stimulus drives every input a fixed delay after the rising edge. It writes modes only with run low, except where it deliberately tries a write while running to exercise R9. It walks every mode code, reserved ones included, with irregular period strobes and random channel waveforms. A behavioural model in the bench is compared with the outputs on every cycle.

// File: rtl/phase_rotator.sv
module phase_rotator (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       period_end,
  input  logic       wr_en,
  input  logic [2:0] wr_mode,
  input  logic [3:0] pwm_in,
  output logic [3:0] pwm_out,
  output logic [1:0] phase_a,
  output logic       phase_b
);
  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_TWO  = 3'd1;
  localparam logic [2:0] M_THR  = 3'd2;
  localparam logic [2:0] M_FOUR = 3'd3;
  localparam logic [2:0] M_PAIR = 3'd4;

  logic [2:0] mode_q;
  logic [2:0] eff;
  logic       run_q;
  logic [1:0] idx_a;
  logic       idx_b;
  logic [1:0] last_a;
  logic [3:0] mask;

  assign eff = (mode_q > M_PAIR) ? M_OFF : mode_q;

  always_comb begin
    case (eff)
      M_TWO, M_PAIR: last_a = 2'd1;
      M_THR:         last_a = 2'd2;
      M_FOUR:        last_a = 2'd3;
      default:       last_a = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      run_q  <= 1'b0;
      idx_a  <= '0;
      idx_b  <= 1'b0;
    end else begin
      run_q <= run;
      if (wr_en && !run) begin
        mode_q <= wr_mode;
        idx_a  <= '0;
        idx_b  <= 1'b0;
      end else if (run && !run_q) begin
        idx_a <= '0;
        idx_b <= 1'b0;
      end else if (run && period_end) begin
        idx_a <= (idx_a == last_a) ? 2'd0 : idx_a + 2'd1;
        if (eff == M_PAIR) idx_b <= ~idx_b;
      end
    end
  end

  always_comb begin
    case (eff)
      M_TWO:   mask = {2'b11, idx_a == 2'd1, idx_a == 2'd0};
      M_THR:   mask = {1'b1, idx_a == 2'd2, idx_a == 2'd1, idx_a == 2'd0};
      M_FOUR:  mask = 4'b0001 << idx_a;
      M_PAIR:  mask = {idx_b, ~idx_b, idx_a[0], ~idx_a[0]};
      default: mask = 4'b1111;
    endcase
  end

  assign pwm_out = pwm_in & mask;
  assign phase_a = idx_a;
  assign phase_b = idx_b;
endmodule

// File: rtl/phase_rotator_chk.sv
module phase_rotator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       period_end,
  input logic       wr_en,
  input logic [2:0] mode_q,
  input logic [3:0] pwm_in,
  input logic [3:0] pwm_out,
  input logic [1:0] phase_a,
  input logic       phase_b
);
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (phase_a == 2'd0 && phase_b == 1'b0));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> ($stable(phase_a) && $stable(phase_b)));

  a_r5_one_of_four: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3) |-> $onehot0(pwm_out));

  a_r6_pairs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4) |-> ($onehot0(pwm_out[1:0]) && $onehot0(pwm_out[3:2])));

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 || mode_q > 3'd4) |-> (pwm_out == pwm_in && phase_a == 2'd0));

  a_r7_pair_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 || mode_q == 3'd4) |-> (phase_a < 2'd2));

  a_r7_no_spurious_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !wr_en && !$rose(run)) |=> $stable(phase_a));
endmodule

bind phase_rotator phase_rotator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .period_end(period_end),
  .wr_en(wr_en), .mode_q(mode_q), .pwm_in(pwm_in), .pwm_out(pwm_out),
  .phase_a(phase_a), .phase_b(phase_b)
);

// File: tb/test_phase_rotator.sv
`timescale 1ns/100ps
module test_phase_rotator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       period_end = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_mode = 3'd0;
  logic [3:0] pwm_in = 4'd0;
  logic [3:0] pwm_out;
  logic [1:0] phase_a;
  logic       phase_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_mode = 0, m_a = 0, m_b = 0;
  bit m_runprev = 0;

  always #2.5 clk = ~clk;

  phase_rotator i_phase_rotator (
    .clk(clk), .rst_n(rst_n), .run(run), .period_end(period_end),
    .wr_en(wr_en), .wr_mode(wr_mode), .pwm_in(pwm_in),
    .pwm_out(pwm_out), .phase_a(phase_a), .phase_b(phase_b)
  );

  function automatic int gsize(int m);
    case (m)
      1, 4: return 2;
      2: return 3;
      3: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic string req_of(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [3:0] exp_out(int m, int a, int b, logic [3:0] pin);
    logic [3:0] k;
    k = 4'b1111;
    case (m)
      1: begin k[0] = (a == 0); k[1] = (a == 1); end
      2: for (int i = 0; i < 3; i++) k[i] = (a == i);
      3: for (int i = 0; i < 4; i++) k[i] = (a == i);
      4: begin k[0] = (a == 0); k[1] = (a == 1); k[2] = (b == 0); k[3] = (b == 1); end
      default: k = 4'b1111;
    endcase
    return pin & k;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_a = 0; m_b = 0; m_runprev = 0;
    end else begin
      if (wr_en && !run) begin
        m_mode = wr_mode; m_a = 0; m_b = 0;
      end else if (run && !m_runprev) begin
        m_a = 0; m_b = 0;
      end else if (run && period_end) begin
        m_a = (m_a + 1) % gsize(m_mode > 4 ? 0 : m_mode);
        if (m_mode == 4) m_b = (m_b + 1) % 2;
      end
      m_runprev = run;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int em;
      em = (m_mode > 4) ? 0 : m_mode;
      check(req_of(em), pwm_out, exp_out(em, m_a, m_b, pwm_in));
      check("R7", {phase_b, phase_a}, {m_b[0], m_a[1:0]});
    end
  end

  task automatic step(bit r, bit pe, bit we, int wm, logic [3:0] pin);
    @(posedge clk);
    #1;
    run = r; period_end = pe; wr_en = we; wr_mode = wm[2:0]; pwm_in = pin;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(0, 0, 0, 0, 4'hF);
    step(0, 0, 0, 0, 4'hF);
    step(0, 0, 0, 0, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pwm_out, 4'hF);
    check("R1", {phase_b, phase_a}, 0);

    for (int m = 0; m < 8; m++) begin
      step(0, 0, 1, m, 4'h0);
      step(0, 0, 0, 0, 4'h0);
      step(1, 0, 0, 0, $urandom);
      for (int c = 0; c < 24; c++)
        step(1, (c % 3 != 1), 0, 0, $urandom);
      step(1, 0, 0, 0, 4'hF);
      step(1, 1, 0, 0, 4'hF);
      step(1, 1, 0, 0, 4'hF);
      step(0, 0, 0, 0, 4'h0);
    end

    // R8: period strobes while stopped leave the index alone
    step(0, 0, 1, 3, 4'hF);
    step(1, 0, 0, 0, 4'hF);
    step(1, 1, 0, 0, 4'hF);
    step(1, 1, 0, 0, 4'hF);
    step(0, 0, 0, 0, 4'hF);
    settle();
    check("R8", phase_a, 2);
    step(0, 1, 0, 0, 4'hF);
    step(0, 1, 0, 0, 4'hF);
    step(0, 0, 0, 0, 4'hF);
    settle();
    check("R8", phase_a, 2);
    check("R8", pwm_out, 4'b0100);

    // R10: starting the timer clears the index
    step(1, 1, 0, 0, 4'hF);
    step(1, 0, 0, 0, 4'hF);
    settle();
    check("R10", phase_a, 0);
    check("R10", pwm_out, 4'b0001);

    // R9: write while running ignored; mode 3 rotation continues
    step(1, 0, 1, 0, 4'hF);
    step(1, 1, 0, 0, 4'hF);
    step(1, 0, 0, 0, 4'hF);
    settle();
    check("R9", phase_a, 1);
    check("R9", pwm_out, 4'b0010);

    // R9: write while stopped taken and clears index
    step(0, 0, 1, 1, 4'hF);
    step(0, 0, 0, 0, 4'hF);
    settle();
    check("R9", phase_a, 0);
    check("R3", pwm_out, 4'b1101);

    // R7: mode 100 both pairs step together
    step(0, 0, 1, 4, 4'hF);
    step(1, 0, 0, 0, 4'hF);
    step(1, 1, 0, 0, 4'hF);
    step(1, 0, 0, 0, 4'hF);
    settle();
    check("R7", {phase_b, phase_a}, 3'b101);
    check("R6", pwm_out, 4'b1010);

    step(0, 0, 0, 0, 4'h0);
    settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule